// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier with HI/LO Result Registers

This unit multiplies two 32-bit operands over several clock cycles and leaves the 64-bit product in a pair of result registers: HI holds the upper word and LO the lower word. A one-cycle start pulse loads the operands and a signed/unsigned select. While the product forms, `busy` stays high. A single-cycle `done` pulse marks the cycle in which HI and LO first hold the final product.

Each step retires two multiplier bits. A three-bit code is built from the two lowest bits of LO and a saved bit. This code chooses zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. A 34-bit adder/subtractor applies that choice to the HI register, which carries two guard bits. The combined HI/LO pair then shifts right by two, and the new product bits drop into LO as the multiplier bits leave it. There is no separate accumulator.

Unsigned operands are zero-extended, so they need one extra step that adds the correction from the top multiplier group. This step adds without shifting. Between operations, software reads HI and LO directly from the output ports and can overwrite either register through the move-to write strobes.

Top module: `booth_hilo_mul`

## Requirements
- R1: When `start` is sampled high with `busy` low and `is_signed`=1, the two's-complement product of `op_a` and `op_b` appears on {`hi_out`,`lo_out`}. This happens at the 16th rising edge after the accepting edge, and `done` is high for the cycle that follows that edge.
- R2: With `is_signed`=0, both operands are taken as unsigned and the unsigned product appears at the 17th rising edge after the accepting edge, with `done` following as in R1.
- R3: `busy` is high from the edge that accepts `start` until the edge that writes the final product. `done` is high for exactly one cycle, and only in the cycle right after `busy` falls.
- R4: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands, its mode and its step count.
- R5: With `busy` low and `start` low, `wr_hi`=1 loads `wr_data` into HI and `wr_lo`=1 loads `wr_data` into LO. The new value shows on `hi_out`/`lo_out` after the next rising edge.
- R6: Move-to writes are discarded when `busy` is high, or when `start` is accepted in the same cycle.
- R7: During reset `hi_out`, `lo_out`, `busy` and `done` are all zero.
- R8: The step code {LO[1], LO[0], saved bit} is decoded as follows. The saved bit is LO[1] from the previous step and is 0 at the first step. Codes 000 and 111 add zero. Codes 001 and 010 add the multiplicand M. Code 011 adds 2M. Code 100 subtracts 2M. Codes 101 and 110 subtract M.
- R9: While idle with no start and no write strobe, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply (taken only when idle) |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| wr_hi | input | 1 | Move-to-HI strobe |
| wr_lo | input | 1 | Move-to-LO strobe |
| wr_data | input | 32 | Data for move-to writes |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| hi_out | output | 32 | HI register (upper product word) |
| lo_out | output | 32 | LO register (lower product word) |

## Verification
The bench targets the operand patterns that stress the Booth recoding:
- The most negative value squared, and the most negative value times the most positive value. A narrow or wrongly extended partial sum overflows on these and corrupts HI.
- All-ones unsigned operands and alternating-bit patterns, which exercise every step code. Here a missing seventeenth step or a dropped top correction leaves HI short by exactly the multiplicand.

It also sends start and move-to strobes during a running operation and in the same cycle as an accepted start. A design that honours them restarts the count or overwrites partial product bits, and the final product comes out wrong.

The step count is checked separately for both modes, so an off-by-one in the counter shows up as `done` arriving a cycle early or late.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
package booth_mul_pkg;

  // Decoded action of one radix-4 recoding group.
  typedef struct packed {
    logic zero;  // contribute nothing
    logic dbl;   // use twice the multiplicand
    logic neg;   // subtract instead of add
  } booth_sel_t;

  // Group code {b(i+1), b(i), b(i-1)} -> digit in {-2,-1,0,+1,+2}.
  function automatic booth_sel_t booth_decode(input logic [2:0] code);
    booth_sel_t s;
    s.zero = (code == 3'b000) || (code == 3'b111);
    s.dbl  = (code == 3'b011) || (code == 3'b100);
    s.neg  = code[2] && !s.zero;
    return s;
  endfunction

  // Two guard bits placed above a 32-bit operand.
  function automatic logic [1:0] guard_bits(input logic msb, input logic sgn);
    return {2{msb & sgn}};
  endfunction

endpackage

// File: rtl/booth_sel_unit.sv
`timescale 1ns/1ps
module booth_sel_unit
  import booth_mul_pkg::*;
#(
  parameter int XW = 34
) (
  input  logic [2:0]    code,
  input  logic [XW-1:0] mcand,
  output logic [XW-1:0] magnitude,
  output logic          sub
);
  booth_sel_t sel;

  always_comb begin
    sel = booth_decode(code);
    if (sel.zero)
      magnitude = '0;
    else if (sel.dbl)
      magnitude = {mcand[XW-2:0], 1'b0};
    else
      magnitude = mcand;
    sub = sel.neg;
  end
endmodule

// File: rtl/booth_addsub.sv
`timescale 1ns/1ps
module booth_addsub #(
  parameter int XW = 34
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic          sub,
  output logic [XW-1:0] y
);
  logic [XW-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    y     = a + b_eff + {{(XW-1){1'b0}}, sub};
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
`timescale 1ns/1ps
module booth_seq_ctrl #(
  parameter int STEPS_S = 16,
  parameter int STEPS_U = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_signed,
  output logic accept,
  output logic busy,
  output logic done,
  output logic last_step,
  output logic extra_step
);
  localparam int CW = $clog2(STEPS_U);
  localparam logic [CW-1:0] LAST_S = CW'(STEPS_S - 1);
  localparam logic [CW-1:0] LAST_U = CW'(STEPS_U - 1);

  logic [CW-1:0] cnt_q;
  logic          unsigned_q;

  always_comb begin
    accept     = start && !busy;
    last_step  = busy && (cnt_q == (unsigned_q ? LAST_U : LAST_S));
    extra_step = busy && unsigned_q && (cnt_q == LAST_U);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cnt_q      <= '0;
      unsigned_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        cnt_q      <= '0;
        unsigned_q <= !is_signed;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3: the step counter never passes the longest sequence
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(STEPS_U)));

  // R4: a start seen while busy neither restarts nor stalls the count
  a_r4_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/booth_hilo_mul.sv
`timescale 1ns/1ps
module booth_hilo_mul
  import booth_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  localparam int XW      = W + 2;
  localparam int STEPS_S = W / 2;
  localparam int STEPS_U = W / 2 + 1;

  logic [XW-1:0] hi_q;
  logic [W-1:0]  lo_q;
  logic          prev_q;
  logic [XW-1:0] mcand_q;

  logic          accept;
  logic          last_step;
  logic          extra_step;
  logic          shift_en;
  logic [2:0]    step_code;
  logic [XW-1:0] addend;
  logic          do_sub;
  logic [XW-1:0] alu_y;

  booth_seq_ctrl #(.STEPS_S(STEPS_S), .STEPS_U(STEPS_U)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_signed  (is_signed),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .last_step  (last_step),
    .extra_step (extra_step)
  );

  // The extra unsigned step sees the zero bits above the multiplier.
  always_comb begin
    step_code = extra_step ? {2'b00, prev_q} : {lo_q[1:0], prev_q};
    shift_en  = busy && !extra_step;
  end

  booth_sel_unit #(.XW(XW)) u_sel (
    .code      (step_code),
    .mcand     (mcand_q),
    .magnitude (addend),
    .sub       (do_sub)
  );

  booth_addsub #(.XW(XW)) u_alu (
    .a   (hi_q),
    .b   (addend),
    .sub (do_sub),
    .y   (alu_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      prev_q  <= 1'b0;
      mcand_q <= '0;
    end else if (accept) begin
      hi_q    <= '0;
      lo_q    <= op_b;
      prev_q  <= 1'b0;
      mcand_q <= {guard_bits(op_a[W-1], is_signed), op_a};
    end else if (shift_en) begin
      hi_q    <= {{2{alu_y[XW-1]}}, alu_y[XW-1:2]};
      lo_q    <= {alu_y[1:0], lo_q[W-1:2]};
      prev_q  <= lo_q[1];
    end else if (busy) begin
      hi_q    <= alu_y;
    end else begin
      if (wr_hi) hi_q <= {2'b00, wr_data};
      if (wr_lo) lo_q <= wr_data;
    end
  end

  assign hi_out = hi_q[W-1:0];
  assign lo_out = lo_q;

  // R8: code 011 adds twice the multiplicand
  a_r8_code_plus_2m: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_code == 3'b011) |-> (alu_y == hi_q + {mcand_q[XW-2:0], 1'b0}));

  // R8: code 100 subtracts twice the multiplicand
  a_r8_code_minus_2m: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_code == 3'b100) |-> (alu_y == hi_q - {mcand_q[XW-2:0], 1'b0}));

  // R8: codes 101 and 110 subtract the multiplicand once
  a_r8_code_minus_m: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (step_code == 3'b101 || step_code == 3'b110)) |-> (alu_y == hi_q - mcand_q));

  // R8: uniform codes leave the partial sum unchanged
  a_r8_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (step_code == 3'b000 || step_code == 3'b111)) |-> (alu_y == hi_q));

  // R3: done is a single-cycle pulse right after busy falls
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: an idle move-to-LO write lands on the next edge
  a_r5_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && wr_lo) |=> (lo_out == $past(wr_data)));

  // R6: an accepted start wins over a same-cycle write
  a_r6_start_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (lo_out == $past(op_b) && hi_out == '0));

  // R9: idle registers hold
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !wr_hi && !wr_lo) |=> ($stable(hi_out) && $stable(lo_out)));
endmodule

// File: tb/test_booth_hilo_mul.sv
`timescale 1ns/1ps
module test_booth_hilo_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        wr_hi = 1'b0;
  logic        wr_lo = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy, done;
  logic [31:0] hi_out, lo_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R7 reset";
  logic [31:0] rng = 32'h1357_9bdf;

  booth_hilo_mul i_booth_hilo_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .op_a(op_a), .op_b(op_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .busy(busy), .done(done),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [63:0] m_res = '0;
  int          m_left = 0;

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                           input logic sgn);
    longint sp;
    logic [63:0] ua, ub;
    if (sgn) begin
      sp = longint'($signed(a)) * longint'($signed(b));
      return sp;
    end
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_hi <= '0; m_lo <= '0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_hi   <= m_res[63:32];
          m_lo   <= m_res[31:0];
        end else begin
          m_left <= m_left - 1;
        end
      end else if (start) begin
        m_busy <= 1'b1;
        m_left <= is_signed ? 16 : 17;
        m_res  <= ref_prod(op_a, op_b, is_signed);
      end else begin
        if (wr_hi) m_hi <= wr_data;
        if (wr_lo) m_lo <= wr_data;
      end
    end
  end

  // Compare away from the active edge, every cycle out of reset
  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R3 (%s) busy: got %0b expected %0b", phase, busy, m_busy);
      end
      if (done !== m_done) begin
        fails++;
        $display("FAIL R3 (%s) done: got %0b expected %0b", phase, done, m_done);
      end
      if (!m_busy) begin
        checks += 2;
        if (hi_out !== m_hi) begin
          fails++;
          $display("FAIL %s hi_out: got %h expected %h", phase, hi_out, m_hi);
        end
        if (lo_out !== m_lo) begin
          fails++;
          $display("FAIL %s lo_out: got %h expected %h", phase, lo_out, m_lo);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input logic sgn);
    @(negedge clk);
    op_a = a; op_b = b; is_signed = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  initial begin
    logic [31:0] ra;
    // R7: reset state
    @(negedge clk);
    @(negedge clk);
    checks += 4;
    if (hi_out !== '0) begin fails++; $display("FAIL R7 hi_out: got %h expected 0", hi_out); end
    if (lo_out !== '0) begin fails++; $display("FAIL R7 lo_out: got %h expected 0", lo_out); end
    if (busy !== 1'b0) begin fails++; $display("FAIL R7 busy: got %0b expected 0", busy); end
    if (done !== 1'b0) begin fails++; $display("FAIL R7 done: got %0b expected 0", done); end
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R1 signed";
    run_mul(32'd3, 32'd5, 1'b1);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b1);
    run_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
    run_mul(-32'sd7, 32'd6, 1'b1);
    run_mul(32'd0, 32'h9ABC_DEF0, 1'b1);
    run_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);

    phase = "R2 unsigned";
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_mul(32'h8000_0000, 32'd2, 1'b0);
    run_mul(32'd1, 32'hFFFF_FFFF, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'h8000_0001, 1'b0);

    phase = "R8 booth codes";
    run_mul(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    run_mul(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    run_mul(32'hC3C3_C3C3, 32'h3C6D_9B1E, 1'b1);
    run_mul(32'h8000_0000, 32'hB6DB_6DB6, 1'b0);

    for (int i = 0; i < 40; i++) begin
      next_rng(); ra = rng;
      next_rng();
      run_mul(ra, rng, rng[7]);
    end

    phase = "R4 start while busy";
    @(negedge clk);
    op_a = 32'hDEAD_0001; op_b = 32'h0000_0F0F; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op_a = 32'h1111_1111; op_b = 32'h2222_2222; is_signed = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    phase = "R5 move-to";
    @(negedge clk);
    wr_data = 32'hCAFE_F00D; wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0; wr_data = 32'h0123_4567; wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0; wr_data = 32'hFFFF_0000; wr_hi = 1'b1; wr_lo = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;

    phase = "R9 idle hold";
    wr_data = 32'h5A5A_5A5A;
    repeat (5) @(negedge clk);

    phase = "R6 move-to while busy";
    op_a = 32'h0000_0101; op_b = 32'hFFFF_FFFE; is_signed = 1'b1; start = 1'b1;
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h7777_7777;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    wr_data = 32'h3333_3333;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    wait_idle();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule